// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block sits next to a small 8-bit CPU core and decides, at each instruction boundary, whether an interrupt is taken and which one. It gathers requests from two external pins (falling-edge triggered, each with its own pending latch and enable), a parameterized set of peripheral flags with their enables, and a software trap strobe. It also watches the global mask bit held in the core.

When the core signals the end of an instruction and an acceptable request exists, the block issues a one-clock take pulse. With it come the vector index of the winning source and a request to set the global mask. A return-from-interrupt strobe carries the mask value that was stacked on entry. The block asks the core to clear the mask only when that stacked value is 0.

A wake output tells the core to leave its low-power wait state whenever an enabled request is pending. A small register port lets software read the external pending latches and enables, write the enables, and clear the latches.

Top module: `irq_ctrl`

## Requirements
- R1: Each external pin passes through a two-flop synchronizer. A high-to-low transition sets that pin's pending latch on the third rising clock edge after the pin is first sampled low. The latch is set whether or not the pin's enable is 1. Register bit 0 is latch A, bit 1 is latch B, bit 2 is enable A, bit 3 is enable B.
- R2: An external or peripheral request can be accepted only when both its latch or flag and its enable are 1 and mask_i is 0.
- R3: A request is accepted only on a clock edge where instr_end_i is 1 and take_o is 0. take_o is then high for exactly the following clock cycle, so two consecutive cycles never both carry take_o.
- R4: Among acceptable requests, the lowest vector index wins. The vector indices are: trap = 0, external A = 1, external B = 2, peripheral k = 3 + k.
- R5: trap_i together with instr_end_i is accepted whatever the value of mask_i, and it always selects vector 0. While mask_i is 1, no other source is accepted.
- R6: set_mask_o is high in exactly the cycles in which take_o is high.
- R7: mask_clr_o is high when iret_i is 1 and iret_mask_i is 0. It is low otherwise, including when iret_i is 1 and iret_mask_i is 1.
- R8: wake_o is high when trap_i is 1, or when any external latch or peripheral flag is 1 together with its enable, regardless of mask_i.
- R9: An external latch is cleared only by a register write that puts 0 in its latch bit or 0 in its enable bit. Writing 1 to a latch bit never sets it. A falling edge detected on the same edge as a clearing write leaves the latch set.
- R10: After reset, both latches and both enables are 0, take_o and set_mask_o are 0, and vec_o is 0.
- R11: vec_o changes only on an edge that starts a take_o pulse, and it keeps its value until the next accepted interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_a_i | input | 1 | External interrupt pin A, falling-edge active |
| ext_b_i | input | 1 | External interrupt pin B, falling-edge active |
| periph_flag_i | input | NUM_PERIPH | Peripheral request flags |
| periph_en_i | input | NUM_PERIPH | Peripheral enable bits |
| trap_i | input | 1 | Software trap instruction executing |
| mask_i | input | 1 | Global interrupt mask bit from the core |
| instr_end_i | input | 1 | Instruction boundary strobe |
| iret_i | input | 1 | Return-from-interrupt strobe |
| iret_mask_i | input | 1 | Mask value restored from the stack |
| reg_we_i | input | 1 | Write strobe for the control register |
| reg_wdata_i | input | 4 | Control register write data |
| reg_rdata_o | output | 4 | Control register read data |
| take_o | output | 1 | Interrupt accepted, one-cycle pulse |
| vec_o | output | VEC_W | Vector index of the accepted source |
| set_mask_o | output | 1 | Request to set the global mask |
| mask_clr_o | output | 1 | Request to clear the global mask on return |
| wake_o | output | 1 | Leave low-power wait |

## Verification
The bench builds the block with NUM_PERIPH = 3. That gives six sources and a vector field that does not fill its power-of-two range, so the top peripheral index (5) and the arbitration between external and peripheral sources are both reachable within a short run. Directed sequences cover the following cases:
- a disabled latch that stays pending;
- a trap under mask;
- a blocked back-to-back boundary;
- a clearing write that collides with a fresh edge.

A randomized phase then drives all inputs against the cycle model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_EXT       = 2;
  localparam int VEC_TRAP      = 0;
  localparam int VEC_EXT_BASE  = 1;
  localparam int VEC_PERIPH    = VEC_EXT_BASE + NUM_EXT;
  localparam int REG_W         = 2 * NUM_EXT;
  // register layout: [NUM_EXT-1:0] latches, [REG_W-1:NUM_EXT] enables
  localparam int REG_LAT_LSB   = 0;
  localparam int REG_EN_LSB    = NUM_EXT;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic s1_q, s2_q, prev_q;

  // idle-high reset avoids a false edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign fall_o = prev_q & ~s2_q;
endmodule

// File: rtl/irq_ext_latch.sv
module irq_ext_latch
  import irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] fall_i,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [NUM_EXT-1:0] pend_o,
  output logic [NUM_EXT-1:0] en_o
);
  logic [NUM_EXT-1:0] pend_q, en_q, clr;
  logic [NUM_EXT-1:0] wr_lat, wr_en;

  assign wr_lat = wdata_i[REG_LAT_LSB +: NUM_EXT];
  assign wr_en  = wdata_i[REG_EN_LSB  +: NUM_EXT];
  assign clr    = {NUM_EXT{we_i}} & (~wr_lat | ~wr_en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | fall_i;  // new edge wins over clear
      if (we_i) en_q <= wr_en;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N = 7,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  localparam int N_SRC = VEC_PERIPH + NUM_PERIPH,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ext_a_i,
  input  logic                  ext_b_i,
  input  logic [NUM_PERIPH-1:0] periph_flag_i,
  input  logic [NUM_PERIPH-1:0] periph_en_i,
  input  logic                  trap_i,
  input  logic                  mask_i,
  input  logic                  instr_end_i,
  input  logic                  iret_i,
  input  logic                  iret_mask_i,
  input  logic                  reg_we_i,
  input  logic [REG_W-1:0]      reg_wdata_i,
  output logic [REG_W-1:0]      reg_rdata_o,
  output logic                  take_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic                  set_mask_o,
  output logic                  mask_clr_o,
  output logic                  wake_o
);
  logic [NUM_EXT-1:0] pins, fall, pend, en;
  logic [N_SRC-1:0]   req;
  logic               sel_valid, accept, take_q;
  logic [VEC_W-1:0]   sel_idx, vec_q;

  assign pins = {ext_b_i, ext_a_i};

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_sync
    irq_edge_sync u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pins[g]),
      .fall_o(fall[g])
    );
  end

  irq_ext_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (fall),
    .we_i   (reg_we_i),
    .wdata_i(reg_wdata_i),
    .pend_o (pend),
    .en_o   (en)
  );

  // trap ignores the mask; all other sources need enable and mask clear
  always_comb begin
    req           = '0;
    req[VEC_TRAP] = trap_i;
    req[VEC_EXT_BASE +: NUM_EXT]  = pend & en & {NUM_EXT{~mask_i}};
    req[VEC_PERIPH +: NUM_PERIPH] = periph_flag_i & periph_en_i & {NUM_PERIPH{~mask_i}};
  end

  irq_prio_sel #(.N(N_SRC)) u_sel (
    .req_i  (req),
    .valid_o(sel_valid),
    .idx_o  (sel_idx)
  );

  assign accept = instr_end_i & sel_valid & ~take_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= accept;
      if (accept) vec_q <= sel_idx;
    end
  end

  assign take_o      = take_q;
  assign vec_o       = vec_q;
  assign set_mask_o  = take_q;
  assign mask_clr_o  = iret_i & ~iret_mask_i;
  assign wake_o      = trap_i | (|(pend & en)) | (|(periph_flag_i & periph_en_i));
  assign reg_rdata_o = {en, pend};
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_PERIPH = 4,
  localparam int VEC_W = $clog2(NUM_PERIPH + 3)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             instr_end_i,
  input logic             trap_i,
  input logic             mask_i,
  input logic             iret_i,
  input logic             iret_mask_i,
  input logic             take_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             mask_clr_o
);
  assert_take_at_boundary_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(instr_end_i));

  assert_take_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  assert_masked_only_trap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(mask_i)) |-> (vec_o == '0));

  assert_trap_taken_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_end_i && trap_i && !take_o) |=> (take_o && vec_o == '0));

  assert_maskable_needs_unmask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vec_o != '0) |-> !$past(mask_i));

  assert_vec_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> $stable(vec_o) || $rose(take_o));

  assert_iret_keep_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iret_i && iret_mask_i) |-> !mask_clr_o);
endmodule

bind irq_ctrl irq_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH)) chk_i (.*);

// File: tb/irq_ctrl_tb_top.sv
module irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 3;
  localparam int NS  = NP + 3;
  localparam int VW  = $clog2(NS);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ext_a_i = 1'b1, ext_b_i = 1'b1;
  logic [NP-1:0] periph_flag_i = '0, periph_en_i = '0;
  logic trap_i = 0, mask_i = 0, instr_end_i = 0, iret_i = 0, iret_mask_i = 0;
  logic reg_we_i = 0;
  logic [3:0] reg_wdata_i = '0;
  logic [3:0] reg_rdata_o;
  logic take_o, set_mask_o, mask_clr_o, wake_o;
  logic [VW-1:0] vec_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_ctrl #(.NUM_PERIPH(NP)) dut_i (.*);

  // behavioural reference: pin history, latches, enables, take state
  bit m_h1[2], m_h2[2], m_h3[2], m_pend[2], m_en[2];
  bit m_take;
  int m_vec;

  function automatic int pick();
    bit pins_ok [2];
    pins_ok[0] = m_pend[0] && m_en[0] && !mask_i;
    pins_ok[1] = m_pend[1] && m_en[1] && !mask_i;
    if (trap_i) return 0;
    if (pins_ok[0]) return 1;
    if (pins_ok[1]) return 2;
    for (int k = 0; k < NP; k++)
      if (periph_flag_i[k] && periph_en_i[k] && !mask_i) return 3 + k;
    return -1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 2; i++) begin
        m_h1[i] = 1; m_h2[i] = 1; m_h3[i] = 1; m_pend[i] = 0; m_en[i] = 0;
      end
      m_take = 0; m_vec = 0;
    end else begin
      int w;
      bit pin[2];
      w = pick();
      if (instr_end_i && !m_take && w >= 0) begin
        m_take = 1; m_vec = w;
      end else m_take = 0;
      pin[0] = ext_a_i; pin[1] = ext_b_i;
      for (int i = 0; i < 2; i++) begin
        bit fall, clr;
        fall = m_h3[i] && !m_h2[i];
        clr  = reg_we_i && (!reg_wdata_i[i] || !reg_wdata_i[2+i]);
        if (clr) m_pend[i] = 0;
        if (fall) m_pend[i] = 1;
        if (reg_we_i) m_en[i] = reg_wdata_i[2+i];
        m_h3[i] = m_h2[i]; m_h2[i] = m_h1[i]; m_h1[i] = pin[i];
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) if (rst_ni && !done) begin
    bit ew;
    ew = trap_i || (m_pend[0] && m_en[0]) || (m_pend[1] && m_en[1])
         || ((periph_flag_i & periph_en_i) != 0);
    chk("R3 take_o", take_o, m_take);
    chk("R4 vec_o", vec_o, m_vec);
    chk("R6 set_mask_o", set_mask_o, m_take);
    chk("R7 mask_clr_o", mask_clr_o, iret_i && !iret_mask_i);
    chk("R8 wake_o", wake_o, ew);
    chk("R1 reg_rdata_o", reg_rdata_o, {m_en[1], m_en[0], m_pend[1], m_pend[0]});
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic wr(logic [3:0] d);
    reg_we_i = 1; reg_wdata_i = d; step(); reg_we_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3); rst_ni = 1; step();
    chk("R10 rdata", reg_rdata_o, 0); chk("R10 take", take_o, 0);
    chk("R10 vec", vec_o, 0); chk("R10 set_mask", set_mask_o, 0);

    // R1: pin A falls while disabled; latch after third edge
    ext_a_i = 0; step(2); chk("R1 not yet", reg_rdata_o[0], 0);
    step(); chk("R1 latch A", reg_rdata_o[0], 1);
    chk("R8 disabled no wake", wake_o, 0);
    instr_end_i = 1; step(); instr_end_i = 0;
    chk("R2 disabled not taken", take_o, 0);

    wr(4'b0101);  // enable A, keep latch A
    chk("R8 wake", wake_o, 1);
    mask_i = 1; instr_end_i = 1; step();
    chk("R2 masked not taken", take_o, 0);
    mask_i = 0; step(); instr_end_i = 0;
    chk("R2 taken", take_o, 1); chk("R4 vec A", vec_o, 1);
    step(); chk("R3 one pulse", take_o, 0); chk("R11 vec held", vec_o, 1);
    step(2); chk("R3 no boundary no take", take_o, 0);

    // R5: trap under mask; back-to-back boundary blocked
    mask_i = 1; trap_i = 1; instr_end_i = 1; step();
    chk("R5 trap taken", take_o, 1); chk("R5 trap vec", vec_o, 0);
    step(); chk("R3 blocked after take", take_o, 0);
    step(); chk("R5 trap again", take_o, 1);
    trap_i = 0; step(); chk("R5 mask blocks others", take_o, 0);
    step(); chk("R5 mask blocks others", take_o, 0);
    instr_end_i = 0; mask_i = 0;

    // R4: priority A > B > peripherals
    ext_b_i = 0; step(3);
    wr(4'b1111);
    periph_en_i = 3'b110; periph_flag_i = 3'b011;
    instr_end_i = 1; step(); instr_end_i = 0;
    chk("R4 A first", vec_o, 1);
    wr(4'b1110);
    chk("R9 write 0 clears A", reg_rdata_o[0], 0);
    instr_end_i = 1; step(); instr_end_i = 0;
    chk("R4 B next", vec_o, 2);
    wr(4'b0111);
    chk("R9 disable clears B, 1 does not set A", reg_rdata_o, 4'b0100);
    instr_end_i = 1; step(); instr_end_i = 0;
    chk("R4 peripheral 1", vec_o, 4);
    periph_en_i = 3'b111; periph_flag_i = 3'b100; step();
    instr_end_i = 1; step(); instr_end_i = 0;
    chk("R4 top peripheral", vec_o, 5);

    // R8: wake with mask set
    mask_i = 1; step(); chk("R8 wake under mask", wake_o, 1);
    periph_flag_i = 0; mask_i = 0; step(); chk("R8 idle", wake_o, 0);

    // R7
    iret_i = 1; iret_mask_i = 0; #1 chk("R7 clear", mask_clr_o, 1);
    iret_mask_i = 1; #1 chk("R7 keep", mask_clr_o, 0);
    step(); iret_i = 0;

    // R9: edge on the same edge as a clearing write
    ext_a_i = 1; ext_b_i = 1; step(4);
    ext_a_i = 0; step(2);
    reg_we_i = 1; reg_wdata_i = 4'b0100; step(); reg_we_i = 0;
    chk("R9 edge wins", reg_rdata_o[0], 1);

    // mixed phase against the model
    for (int c = 0; c < 400; c++) begin
      ext_a_i = $urandom_range(0, 1); ext_b_i = $urandom_range(0, 1);
      periph_flag_i = NP'($urandom); periph_en_i = NP'($urandom);
      trap_i = ($urandom_range(0, 7) == 0); mask_i = $urandom_range(0, 1);
      instr_end_i = $urandom_range(0, 1);
      iret_i = $urandom_range(0, 1); iret_mask_i = $urandom_range(0, 1);
      reg_we_i = ($urandom_range(0, 5) == 0); reg_wdata_i = 4'($urandom);
      step();
    end
    reg_we_i = 0; instr_end_i = 0; trap_i = 0;
    step(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule